// File: doc/BRIEF.md
# Data EEPROM Access Controller

This block sits between a CPU bus and a small byte-wide non-volatile data array, modelled here as on-chip registers. Software reads the array directly when the controller is idle. To change bytes, it first sets a latch-mode control bit. It then writes up to one row's worth of bytes into page latches, and sets a program-start bit. A counter stands in for the physical programming time. When the counter expires, the latched bytes are committed to the array and both control bits drop.

The controller also follows the chip's low-power requests. A wait or active-halt request is honoured at once when the block is idle. If a programming cycle is running, the request is held back until that cycle ends. A halt request stops everything immediately. An interrupted programming cycle marks the bytes it was writing with a per-byte corruption flag, which is returned with each read. The cycle can be cut short by halt, by reset, or by software dropping a control bit.

A read-out protection bit blocks array reads and refuses latch mode. Clearing it starts an automatic sweep that erases every byte to all ones before access is allowed again.

Top module: `eeprom_ctrl`

## Requirements
- R1: After power-on reset, the control bits, busy, and protection are 0, `pwr_state` is 0 (run), and every array byte reads 8'hFF with the corruption flag clear.
- R2: A read issued while the latch-mode bit is set yields `bus_rvalid`=0 and `bus_rdata`=0 one cycle later.
- R3: A read issued while idle in run state yields `bus_rvalid`=1 one cycle later, with the addressed byte on `bus_rdata` and its corruption flag on `bus_rbad`.
- R4: A bus write issued while the latch-mode bit is clear is ignored: no latch captures it, and a following programming cycle leaves that byte unchanged.
- R5: Latch writes collect bytes of one aligned row of ROW_BYTES bytes; the first write picks the row. A later write to another row is dropped. A repeated write to the same byte replaces its latched value.
- R6: A control write with both latch (`ctl_latch_in`) and start (`ctl_prog_in`) set starts a programming cycle. `busy` then reads 1 for exactly PROG_CYCLES samples. At expiry, the latched bytes are written, all other bytes stay unchanged, both control bits clear, and the latches empty.
- R7: A wait (`pwr_req`=1) or active-halt (`pwr_req`=2) request while not busy sets `pwr_state` to 1 (wait) on the next cycle. Bus and control accesses are ignored while asleep. `pwr_wake` returns the block to run (0).
- R8: A wait or active-halt request during a programming cycle leaves `pwr_state` at 0 until the cycle completes. `pwr_state` becomes 1 at the same edge that commits the data.
- R9: A halt request (`pwr_req`=3) sets `pwr_state` to 2 on the next cycle and cancels any programming cycle. The targeted bytes keep their old value and read back with `bus_rbad`=1. A halt in the expiry cycle wins over the commit.
- R10: A programming cycle cut short by software is aborted, with its targeted bytes flagged as corrupt. Software cuts a cycle short with a control write that clears either bit. Assertion of `rst_n` during a cycle has the same effect.
- R11: A byte that is later programmed successfully reads back with `bus_rbad`=0.
- R12: While protection is on, reads return `bus_rvalid`=0 and latch mode cannot be set. Protection is set by `prot_wr` with `prot_val`=1, and only while not busy.
- R13: Clearing protection (`prot_wr` with `prot_val`=0) keeps `prot_on` at 1 for exactly 2^ADDR_W cycles. During those cycles every byte is erased to 8'hFF with its corruption flag cleared. Access is restored afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; initialises the array and protection |
| rst_n | input | 1 | Synchronous controller reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | 1 when read data is driven, 0 when the read was refused |
| bus_rbad | output | 1 | Corruption flag of the byte read |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_latch_in | input | 1 | Latch-mode bit value for the control write |
| ctl_prog_in | input | 1 | Program-start bit value for the control write |
| ctl_latch | output | 1 | Current latch-mode bit |
| ctl_prog | output | 1 | Current program-start bit |
| busy | output | 1 | Programming cycle running |
| pwr_req | input | 2 | Low-power request: 0 none, 1 wait, 2 active-halt, 3 halt |
| pwr_wake | input | 1 | Return to run from wait or halt |
| pwr_state | output | 2 | 0 run, 1 wait, 2 halt |
| prot_wr | input | 1 | Protection bit write strobe |
| prot_val | input | 1 | Protection value to write |
| prot_on | output | 1 | Protection active, including the erase sweep |

## Verification
Three pairs of functions can land on the same clock edge here.

The programming timer's expiry can meet a halt request. The bench counts exactly PROG_CYCLES-1 edges after the start, then drives the halt. It judges the result by reading back the corruption flag and the old value, and by seeing `pwr_state` at 2.

A wait request can sit pending while the commit occurs. Here the bench requires `pwr_state` to stay 0 up to the last busy sample and to read 1 on the first sample after it.

A reset can meet a running cycle. That case is judged by the corruption flag after reset is released.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    PW_RUN  = 2'd0,
    PW_WAIT = 2'd1,
    PW_HALT = 2'd2
  } pwr_t;

  localparam logic [1:0] REQ_NONE  = 2'd0;
  localparam logic [1:0] REQ_WAIT  = 2'd1;
  localparam logic [1:0] REQ_AHALT = 2'd2;
  localparam logic [1:0] REQ_HALT  = 2'd3;

  // A request that parks the block until woken, without cancelling work.
  function automatic logic is_soft_sleep(input logic [1:0] req);
    return (req == REQ_WAIT) || (req == REQ_AHALT);
  endfunction
endpackage

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
  parameter int ADDR_W    = 6,
  parameter int ROW_BYTES = 4,
  localparam int ROW_W    = $clog2(ROW_BYTES),
  localparam int ROW_A    = ADDR_W - ROW_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   clear,
  output logic [ROW_A-1:0]       row,
  output logic [ROW_BYTES-1:0]   valid,
  output logic [ROW_BYTES*8-1:0] data
);
  function automatic logic [ROW_A-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ROW_W];
  endfunction

  function automatic logic [ROW_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[ROW_W-1:0];
  endfunction

  logic [ROW_A-1:0]       row_q;
  logic [ROW_BYTES-1:0]   valid_q;
  logic [ROW_BYTES*8-1:0] data_q;

  // Named events for the checks below
  logic row_open, row_hit, accept, drop;
  assign row_open = (valid_q == '0);
  assign row_hit  = (row_of(wr_addr) == row_q);
  assign accept   = wr_en && (row_open || row_hit);
  assign drop     = wr_en && !row_open && !row_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      row_q   <= '0;
      valid_q <= '0;
      data_q  <= '0;
    end else if (accept) begin
      row_q                          <= row_of(wr_addr);
      valid_q[col_of(wr_addr)]       <= 1'b1;
      data_q[col_of(wr_addr)*8 +: 8] <= wr_data;
    end
  end

  assign row   = row_q;
  assign valid = valid_q;
  assign data  = data_q;

  // R5
  row_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !clear) |=> ($stable(valid_q) && $stable(data_q) && $stable(row_q)));

  // R5
  row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clear) |=> (valid_q != '0));
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int CYCLES = 20,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic running,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || stop) cnt_q <= '0;
    else if (start)     cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign running = (cnt_q != '0);
  assign expire  = (cnt_q == CNT_W'(1));

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> running);

  // R6
  expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !running);
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
  parameter int ADDR_W    = 6,
  parameter int ROW_BYTES = 4,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int ROW_W    = $clog2(ROW_BYTES),
  localparam int ROW_A    = ADDR_W - ROW_W
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data,
  output logic                   rd_bad,
  input  logic                   commit,
  input  logic                   abort,
  input  logic [ROW_A-1:0]       row,
  input  logic [ROW_BYTES-1:0]   valid,
  input  logic [ROW_BYTES*8-1:0] ldata,
  input  logic                   erase_en,
  input  logic [ADDR_W-1:0]      erase_addr
);
  function automatic logic [ADDR_W-1:0] cell_index(input logic [ROW_A-1:0] r,
                                                    input int unsigned c);
    return {r, ROW_W'(c)};
  endfunction

  logic [7:0] mem_q [DEPTH];
  logic       bad_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= 8'hFF;
        bad_q[i] <= 1'b0;
      end
    end else if (erase_en) begin
      mem_q[erase_addr] <= 8'hFF;
      bad_q[erase_addr] <= 1'b0;
    end else begin
      for (int c = 0; c < ROW_BYTES; c++) begin
        if (valid[c]) begin
          if (commit) begin
            mem_q[cell_index(row, c)] <= ldata[c*8 +: 8];
            bad_q[cell_index(row, c)] <= 1'b0;
          end else if (abort) begin
            bad_q[cell_index(row, c)] <= 1'b1;
          end
        end
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign rd_bad  = bad_q[rd_addr];
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int ROW_BYTES   = 4,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_rbad,
  input  logic              ctl_wr,
  input  logic              ctl_latch_in,
  input  logic              ctl_prog_in,
  output logic              ctl_latch,
  output logic              ctl_prog,
  output logic              busy,
  input  logic [1:0]        pwr_req,
  input  logic              pwr_wake,
  output logic [1:0]        pwr_state,
  input  logic              prot_wr,
  input  logic              prot_val,
  output logic              prot_on
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROW_W = $clog2(ROW_BYTES);
  localparam int ROW_A = ADDR_W - ROW_W;

  // ---------------- state ----------------
  logic        lat_q, prog_q;
  pwr_t        pwr_q;
  logic        pend_q;
  logic        prot_q, erasing_q;
  logic [ADDR_W-1:0] era_ptr_q;
  logic [7:0]  rdata_q;
  logic        rvalid_q, rbad_q;

  // ---------------- named events ----------------
  logic run, blocked, rd_req, wr_req, rd_ok, wr_ok, ctl_ev;
  logic halt_req, wait_req, halt_abort, sw_abort, rst_abort, abort_ev;
  logic start_ev, done_ev, commit_ev, latch_clear;
  logic go_wait, wait_now, wait_defer;
  logic prot_set_ev, prot_clr_ev, erase_step, erase_last;
  logic timer_busy;

  logic [ROW_A-1:0]       lt_row;
  logic [ROW_BYTES-1:0]   lt_valid;
  logic [ROW_BYTES*8-1:0] lt_data;
  logic [7:0]             arr_data;
  logic                   arr_bad;

  assign run      = (pwr_q == PW_RUN);
  assign blocked  = prot_q || erasing_q;
  assign rd_req   = bus_sel && !bus_wr;
  assign wr_req   = bus_sel && bus_wr;
  assign rd_ok    = rd_req && run && !lat_q && !timer_busy && !blocked;
  assign wr_ok    = wr_req && run && lat_q && !timer_busy && !blocked;
  assign ctl_ev   = ctl_wr && run && !erasing_q;

  assign halt_req   = (pwr_req == REQ_HALT) && (pwr_q != PW_HALT);
  assign wait_req   = is_soft_sleep(pwr_req) && run;
  assign halt_abort = halt_req && timer_busy;
  assign sw_abort   = ctl_ev && timer_busy && !(ctl_latch_in && ctl_prog_in) && !halt_req;
  assign rst_abort  = !rst_n && timer_busy;
  assign abort_ev   = halt_abort || sw_abort || rst_abort;

  assign start_ev  = ctl_ev && !timer_busy && ctl_latch_in && ctl_prog_in &&
                     !blocked && !halt_req;
  assign commit_ev = done_ev && rst_n && !halt_abort && !sw_abort;

  assign latch_clear = commit_ev || abort_ev || prot_set_ev ||
                       (ctl_ev && !timer_busy && !ctl_latch_in);

  assign wait_now   = wait_req && !timer_busy;
  assign wait_defer = wait_req && timer_busy;
  assign go_wait    = run && (wait_req || pend_q) &&
                      (!timer_busy || commit_ev || sw_abort);

  assign prot_set_ev = prot_wr && prot_val && !prot_q && !timer_busy && run;
  assign prot_clr_ev = prot_wr && !prot_val && prot_q && !erasing_q &&
                       !timer_busy && run;
  assign erase_step  = erasing_q && run;
  assign erase_last  = erase_step && (era_ptr_q == ADDR_W'(DEPTH - 1));

  // ---------------- sub-blocks ----------------
  eep_page_latch #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ok),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .clear   (latch_clear),
    .row     (lt_row),
    .valid   (lt_valid),
    .data    (lt_data)
  );

  eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_ev),
    .stop    (halt_abort || sw_abort),
    .running (timer_busy),
    .expire  (done_ev)
  );

  eep_cell_array #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_array (
    .clk        (clk),
    .por_n      (por_n),
    .rd_addr    (bus_addr),
    .rd_data    (arr_data),
    .rd_bad     (arr_bad),
    .commit     (commit_ev),
    .abort      (abort_ev),
    .row        (lt_row),
    .valid      (lt_valid),
    .ldata      (lt_data),
    .erase_en   (erase_step),
    .erase_addr (era_ptr_q)
  );

  // ---------------- control bits ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= 1'b0;
      prog_q <= 1'b0;
    end else if (commit_ev || halt_abort || sw_abort || prot_set_ev) begin
      lat_q  <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      if (ctl_ev && !timer_busy) lat_q <= ctl_latch_in && !blocked;
      if (start_ev) prog_q <= 1'b1;
    end
  end

  // ---------------- power state ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= PW_RUN;
      pend_q <= 1'b0;
    end else if (halt_req) begin
      pwr_q  <= PW_HALT;
      pend_q <= 1'b0;
    end else if (!run) begin
      if (pwr_wake) pwr_q <= PW_RUN;
    end else if (go_wait) begin
      pwr_q  <= PW_WAIT;
      pend_q <= 1'b0;
    end else if (wait_defer) begin
      pend_q <= 1'b1;
    end
  end

  // ---------------- protection and erase sweep ----------------
  always_ff @(posedge clk) begin
    if (!por_n) begin
      prot_q    <= 1'b0;
      erasing_q <= 1'b0;
      era_ptr_q <= '0;
    end else if (prot_set_ev) begin
      prot_q <= 1'b1;
    end else if (prot_clr_ev) begin
      erasing_q <= 1'b1;
      era_ptr_q <= '0;
    end else if (erase_last) begin
      erasing_q <= 1'b0;
      prot_q    <= 1'b0;
      era_ptr_q <= '0;
    end else if (erase_step) begin
      era_ptr_q <= era_ptr_q + 1'b1;
    end
  end

  // ---------------- read path ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
      rbad_q   <= 1'b0;
    end else begin
      rvalid_q <= rd_ok;
      rdata_q  <= rd_ok ? arr_data : 8'h00;
      rbad_q   <= rd_ok && arr_bad;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign bus_rbad   = rbad_q;
  assign ctl_latch  = lat_q;
  assign ctl_prog   = prog_q;
  assign busy       = timer_busy;
  assign pwr_state  = pwr_q;
  assign prot_on    = prot_q;

  // ---------------- assertions ----------------
  // R2
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rd_req && lat_q) |=> !bus_rvalid);

  // R6
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    commit_ev |=> (!ctl_latch && !ctl_prog && !busy));

  // R6
  busy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    busy |-> (ctl_latch && ctl_prog));

  // R7
  wait_now_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wait_now |=> (pwr_state == 2'd1));

  // R8
  wait_defer_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wait_defer && !commit_ev && !sw_abort) |=> (pwr_state == 2'd0));

  // R9
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    halt_req |=> (pwr_state == 2'd2 && !busy && !ctl_prog));

  // R12
  prot_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rd_req && prot_on) |=> !bus_rvalid);

  // R12
  prot_latch_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prot_on |=> !(ctl_latch && $rose(ctl_latch)));
endmodule

// File: tb/tb_eeprom_ctrl.sv
module tb_eeprom_ctrl;
  localparam int AW   = 6;
  localparam int RB   = 4;
  localparam int PROG = 20;
  localparam int DEP  = 1 << AW;

  logic clk = 1'b0;
  logic por_n, rst_n;
  logic bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic bus_rvalid, bus_rbad;
  logic ctl_wr, ctl_latch_in, ctl_prog_in, ctl_latch, ctl_prog, busy;
  logic [1:0] pwr_req, pwr_state;
  logic pwr_wake, prot_wr, prot_val, prot_on;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  eeprom_ctrl #(.ADDR_W(AW), .ROW_BYTES(RB), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_rbad(bus_rbad), .ctl_wr(ctl_wr), .ctl_latch_in(ctl_latch_in),
    .ctl_prog_in(ctl_prog_in), .ctl_latch(ctl_latch), .ctl_prog(ctl_prog),
    .busy(busy), .pwr_req(pwr_req), .pwr_wake(pwr_wake),
    .pwr_state(pwr_state), .prot_wr(prot_wr), .prot_val(prot_val),
    .prot_on(prot_on)
  );

  // {address, data} pairs, each programmed as a single-byte cycle
  localparam logic [13:0] VEC [0:5] = '{
    {6'h01, 8'hA5}, {6'h06, 8'h3C}, {6'h11, 8'h00},
    {6'h1F, 8'h81}, {6'h2A, 8'h5A}, {6'h3C, 8'hFE}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic v, output logic [7:0] d,
                    output logic b);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    v = bus_rvalid; d = bus_rdata; b = bus_rbad;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic ctl(input logic l, input logic p);
    ctl_wr = 1'b1; ctl_latch_in = l; ctl_prog_in = p;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pwr(input logic [1:0] r);
    pwr_req = r;
    @(negedge clk);
    pwr_req = 2'd0;
  endtask

  task automatic wake();
    pwr_wake = 1'b1;
    @(negedge clk);
    pwr_wake = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 1;
    while (busy && n < 1000) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic prog_byte(input logic [AW-1:0] a, input logic [7:0] d, output int n);
    ctl(1'b1, 1'b0);
    wr(a, d);
    ctl(1'b1, 1'b1);
    wait_idle(n);
  endtask

  task automatic expect_byte(input string tag, input logic [AW-1:0] a,
                             input logic [7:0] d, input logic b);
    logic v, bb; logic [7:0] dd;
    rd(a, v, dd, bb);
    chk(tag, {23'd0, v, dd}, {23'd0, 1'b1, d});
    chk(tag, {31'd0, bb}, {31'd0, b});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic v, b; logic [7:0] d; int n;
    por_n = 1'b0; rst_n = 1'b0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    ctl_wr = 0; ctl_latch_in = 0; ctl_prog_in = 0;
    pwr_req = 2'd0; pwr_wake = 0; prot_wr = 0; prot_val = 0;
    step(3);
    por_n = 1'b1; rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 control", {28'd0, ctl_latch, ctl_prog, busy, prot_on}, 32'd0);
    chk("R1 pwr_state", {30'd0, pwr_state}, 32'd0);
    expect_byte("R1 erased byte", 6'h05, 8'hFF, 1'b0);

    // R6 vector table: program each pair, check busy length once
    for (int i = 0; i < 6; i++) begin
      prog_byte(VEC[i][13:8], VEC[i][7:0], n);
      if (i == 0) chk("R6 busy length", n, PROG);
      if (i == 0) chk("R6 bits cleared", {30'd0, ctl_latch, ctl_prog}, 32'd0);
    end
    // R3 read-back
    for (int i = 0; i < 6; i++) expect_byte("R3 table readback", VEC[i][13:8], VEC[i][7:0], 1'b0);
    expect_byte("R6 untouched byte", 6'h02, 8'hFF, 1'b0);

    // R5 multi-byte row, foreign row dropped, same byte overwritten
    ctl(1'b1, 1'b0);
    wr(6'h20, 8'h10); wr(6'h21, 8'h11); wr(6'h23, 8'h13);
    wr(6'h24, 8'h44); wr(6'h21, 8'h99);
    ctl(1'b1, 1'b1);
    wait_idle(n);
    expect_byte("R5 byte0", 6'h20, 8'h10, 1'b0);
    expect_byte("R5 overwrite", 6'h21, 8'h99, 1'b0);
    expect_byte("R5 hole", 6'h22, 8'hFF, 1'b0);
    expect_byte("R5 byte3", 6'h23, 8'h13, 1'b0);
    expect_byte("R5 other row", 6'h24, 8'hFF, 1'b0);

    // R2 reads refused in latch mode
    ctl(1'b1, 1'b0);
    rd(6'h20, v, d, b);
    chk("R2 latch read", {23'd0, v, d}, 32'd0);
    ctl(1'b0, 1'b0);
    expect_byte("R2 after leaving latch", 6'h20, 8'h10, 1'b0);

    // R4 write without latch mode ignored
    wr(6'h30, 8'h55);
    ctl(1'b1, 1'b0);
    ctl(1'b1, 1'b1);
    wait_idle(n);
    expect_byte("R4 ignored write", 6'h30, 8'hFF, 1'b0);

    // R7 immediate wait, active-halt, accesses ignored, wake
    pwr(2'd1);
    chk("R7 wait entry", {30'd0, pwr_state}, 32'd1);
    rd(6'h20, v, d, b);
    chk("R7 read while asleep", {31'd0, v}, 32'd0);
    ctl(1'b1, 1'b0);
    chk("R7 ctl ignored asleep", {31'd0, ctl_latch}, 32'd0);
    wake();
    chk("R7 wake", {30'd0, pwr_state}, 32'd0);
    pwr(2'd2);
    chk("R7 active-halt entry", {30'd0, pwr_state}, 32'd1);
    wake();

    // R8 deferred wait during programming
    ctl(1'b1, 1'b0);
    wr(6'h08, 8'h77);
    ctl(1'b1, 1'b1);
    step(3);
    pwr(2'd1);
    chk("R8 still running", {30'd0, pwr_state}, 32'd0);
    chk("R8 busy", {31'd0, busy}, 32'd1);
    while (busy) begin
      chk("R8 run while busy", {30'd0, pwr_state}, 32'd0);
      @(negedge clk);
    end
    chk("R8 wait at commit", {30'd0, pwr_state}, 32'd1);
    wake();
    expect_byte("R8 committed", 6'h08, 8'h77, 1'b0);

    // R9 halt mid-cycle
    ctl(1'b1, 1'b0);
    wr(6'h09, 8'h99);
    ctl(1'b1, 1'b1);
    step(5);
    pwr(2'd3);
    chk("R9 halt state", {29'd0, pwr_state, busy}, {29'd0, 2'd2, 1'b0});
    chk("R9 bits cleared", {30'd0, ctl_latch, ctl_prog}, 32'd0);
    wake();
    expect_byte("R9 corrupt flag", 6'h09, 8'hFF, 1'b1);

    // R9 halt on the expiry edge wins over commit
    ctl(1'b1, 1'b0);
    wr(6'h0A, 8'h66);
    ctl(1'b1, 1'b1);
    step(PROG - 1);
    chk("R9 last busy cycle", {31'd0, busy}, 32'd1);
    pwr(2'd3);
    chk("R9 halt at expiry", {29'd0, pwr_state, busy}, {29'd0, 2'd2, 1'b0});
    wake();
    expect_byte("R9 expiry halt corrupt", 6'h0A, 8'hFF, 1'b1);

    // R11 clean reprogram clears flag
    prog_byte(6'h09, 8'h42, n);
    expect_byte("R11 flag cleared", 6'h09, 8'h42, 1'b0);

    // R10 software abort
    ctl(1'b1, 1'b0);
    wr(6'h0C, 8'h12);
    ctl(1'b1, 1'b1);
    step(3);
    ctl(1'b0, 1'b0);
    chk("R10 sw abort idle", {29'd0, busy, ctl_latch, ctl_prog}, 32'd0);
    expect_byte("R10 sw abort corrupt", 6'h0C, 8'hFF, 1'b1);

    // R10 reset abort
    ctl(1'b1, 1'b0);
    wr(6'h0D, 8'h34);
    ctl(1'b1, 1'b1);
    step(2);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 reset idle", {29'd0, busy, ctl_latch, ctl_prog}, 32'd0);
    expect_byte("R10 reset corrupt", 6'h0D, 8'hFF, 1'b1);

    // R12 protection
    prot_wr = 1'b1; prot_val = 1'b1;
    @(negedge clk);
    prot_wr = 1'b0;
    chk("R12 prot on", {31'd0, prot_on}, 32'd1);
    rd(6'h20, v, d, b);
    chk("R12 read blocked", {23'd0, v, d}, 32'd0);
    ctl(1'b1, 1'b0);
    chk("R12 latch refused", {31'd0, ctl_latch}, 32'd0);

    // R13 clearing protection erases everything
    prot_wr = 1'b1; prot_val = 1'b0;
    @(negedge clk);
    prot_wr = 1'b0;
    n = 1;
    while (prot_on && n < 1000) begin
      rd(6'h20, v, d, b);
      if (v) chk("R13 read during erase", {31'd0, v}, 32'd0);
      if (prot_on) n++;
    end
    chk("R13 erase length", n, DEP);
    expect_byte("R13 erased data", 6'h20, 8'hFF, 1'b0);
    expect_byte("R13 erased corrupt", 6'h0C, 8'hFF, 1'b0);
    expect_byte("R13 erased table", VEC[0][13:8], 8'hFF, 1'b0);

    summary();
    $finish;
  end
endmodule